// File: doc/BRIEF.md
# Low-Power Mode Control Registers

This block is a small APB register slave that owns the power-mode controls of a microcontroller. When the core asserts its deep-sleep signal, the block turns two control bits into a request for one of two low-power modes. One bit picks the power-down (standby) mode over the stop mode. The other bit asks for the low-power regulator while in stop mode. The mode and regulator requests are registered, so the power sequencer sees glitch-free levels one clock after the inputs change.

A second register holds sticky event flags and a few enables. The standby-exit and wakeup flags are set by single-cycle event pulses. Software clears them by writing ones to command bits in the control register. The standby clear acts on the write cycle. The wakeup clear acts two clocks later. The status register has its own reset input (`por_ni`), so a system reset caused by leaving standby does not disturb it. Reads of the status register take one extra APB wait state.

Top module: `pwr_mode_regs`

## Requirements
- R1: One clock after `deepsleep_i` is sampled high with control bit 1 (power-down select) at 1, `stby_req_o` is 1 and `stop_req_o` is 0.
- R2: One clock after `deepsleep_i` is sampled high with control bit 1 at 0, `stop_req_o` is 1 and `reg_lp_o` equals control bit 0 (low-power deep sleep). One clock after `deepsleep_i` is sampled low, all three request outputs are 0.
- R3: A standby-exit event pulse sets status bit 1. Writing 1 to control bit 3 clears it on the write's clock edge. Writing 0 there leaves it alone. Control bit 3 always reads as 0.
- R4: A wakeup event pulse sets status bit 0. Writing 1 to control bit 2 clears it on the second clock edge after the write's edge. Control bit 2 always reads as 0.
- R5: An event pulse on the same edge as a pending clear of its flag leaves the flag set.
- R6: The control register is at offset 0x00 and resets to 0. Bits 4 (detector enable, driven on `det_en_o`), 1 and 0 are read/write. All other bits read as 0.
- R7: The status register is at offset 0x04. Bits 0 and 1 are the flags. Bit 2 mirrors `det_out_i`, bit 3 mirrors `bkreg_rdy_i` and bit 14 mirrors `vscale_rdy_i`; all five are read-only. Bits 8 (`wkpin_en_o`) and 9 (`bkreg_en_o`) are read/write. All other bits read as 0.
- R8: A read of the status register holds `pready_o` low for exactly one access cycle. Every other access completes with no wait state.
- R9: `rst_ni` resets the control register and the requests but not the status register. Only `por_ni` resets the status register, to 0.
- R10: Reads of any other offset return 0. Writes to them change nothing. `pslverr_o` is always 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low async system reset, also asserted on standby exit |
| por_ni | input | 1 | Active-low async power-on reset for the status register |
| psel_i | input | 1 | APB select |
| penable_i | input | 1 | APB enable |
| pwrite_i | input | 1 | APB write |
| paddr_i | input | 8 | APB byte address |
| pwdata_i | input | 32 | APB write data |
| prdata_o | output | 32 | APB read data |
| pready_o | output | 1 | APB ready |
| pslverr_o | output | 1 | APB error, tied low |
| deepsleep_i | input | 1 | Core deep-sleep indication |
| wkup_evt_i | input | 1 | Wakeup event pulse |
| stby_exit_evt_i | input | 1 | Standby-exit event pulse |
| det_out_i | input | 1 | Voltage detector output |
| bkreg_rdy_i | input | 1 | Backup regulator ready |
| vscale_rdy_i | input | 1 | Regulator scaling ready |
| stby_req_o | output | 1 | Standby mode request |
| stop_req_o | output | 1 | Stop mode request |
| reg_lp_o | output | 1 | Regulator low-power request |
| det_en_o | output | 1 | Voltage detector enable |
| wkpin_en_o | output | 1 | Wakeup pin enable |
| bkreg_en_o | output | 1 | Backup regulator enable |

## Verification
The delayed wakeup clear is bracketed by event pulses one and two edges after the write. A clear that lands a cycle early or late therefore leaves the wrong flag value. Event pulses that coincide with a clear expose a design that lets the clear win. The bench pulses `rst_ni` alone after setting flags and enables; a status register wired to the system reset loses them. Every transfer counts its wait cycles, so a missing or extra wait state, or a wait on a write, is caught. The random phase mixes mode bits and deep-sleep levels, which catches a design that swaps the two mode selects or drives `reg_lp_o` during standby.

// File: rtl/pwr_regs_pkg.sv
package pwr_regs_pkg;
  localparam int DATA_W = 32;

  // control register bit positions
  localparam int CT_LP_DEEP = 0;
  localparam int CT_PWRDN   = 1;
  localparam int CT_CLR_WU  = 2;
  localparam int CT_CLR_SB  = 3;
  localparam int CT_DET_EN  = 4;

  // status register bit positions
  localparam int ST_WU      = 0;
  localparam int ST_SB      = 1;
  localparam int ST_DET     = 2;
  localparam int ST_BKR_RDY = 3;
  localparam int ST_WKP_EN  = 8;
  localparam int ST_BKR_EN  = 9;
  localparam int ST_VS_RDY  = 14;

  localparam int CTRL_WORD = 0;
  localparam int STAT_WORD = 1;

  typedef enum logic [1:0] {
    SEL_NONE,
    SEL_CTRL,
    SEL_STAT
  } reg_sel_e;

  typedef struct packed {
    logic det_en;
    logic pwrdn_sel;
    logic lp_deep;
  } ctrl_t;

  typedef struct packed {
    logic bkreg_en;
    logic wkpin_en;
  } stat_rw_t;
endpackage

// File: rtl/pwr_apb_if.sv
module pwr_apb_if
  import pwr_regs_pkg::*;
#(
  parameter int ADDR_W    = 8,
  parameter int STAT_WAIT = 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              psel_i,
  input  logic              penable_i,
  input  logic              pwrite_i,
  input  logic [ADDR_W-1:0] paddr_i,
  output logic              pready_o,
  output logic              wr_stb_o,
  output reg_sel_e          sel_o
);
  localparam int WORD_W = ADDR_W - 2;
  localparam int CNT_W  = (STAT_WAIT > 0) ? $clog2(STAT_WAIT + 1) : 1;

  logic [WORD_W-1:0] word;
  logic              access;
  logic              stat_rd;

  assign word    = paddr_i[ADDR_W-1:2];
  assign access  = psel_i && penable_i;

  always_comb begin
    if (word == WORD_W'(CTRL_WORD))      sel_o = SEL_CTRL;
    else if (word == WORD_W'(STAT_WORD)) sel_o = SEL_STAT;
    else                                 sel_o = SEL_NONE;
  end

  assign stat_rd  = access && !pwrite_i && (sel_o == SEL_STAT);
  assign wr_stb_o = access && pwrite_i && pready_o;

  generate
    if (STAT_WAIT > 0) begin : g_wait
      logic [CNT_W-1:0] wait_cnt;

      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)                   wait_cnt <= '0;
        else if (stat_rd && !pready_o) wait_cnt <= wait_cnt + 1'b1;
        else                           wait_cnt <= '0;
      end

      assign pready_o = !stat_rd || (wait_cnt == CNT_W'(STAT_WAIT));

      // a completed status read was preceded by a stalled cycle of the same access
      p_stat_wait_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (stat_rd && pready_o) |-> $past(stat_rd && !pready_o));
    end else begin : g_nowait
      assign pready_o = 1'b1;
    end
  endgenerate

  p_zero_wait_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (access && !stat_rd) |-> pready_o);
endmodule

// File: rtl/pwr_flags.sv
module pwr_flags #(
  parameter int CLR_DLY = 2
) (
  input  logic clk_i,
  input  logic por_ni,
  input  logic set_sb_i,
  input  logic set_wu_i,
  input  logic clr_sb_i,
  input  logic clr_wu_i,
  output logic sb_o,
  output logic wu_o
);
  logic [CLR_DLY-1:0] wu_pend;
  logic               wu_clr_now;

  generate
    if (CLR_DLY > 1) begin : g_shift
      always_ff @(posedge clk_i or negedge por_ni) begin
        if (!por_ni) wu_pend <= '0;
        else         wu_pend <= {wu_pend[CLR_DLY-2:0], clr_wu_i};
      end
    end else begin : g_single
      always_ff @(posedge clk_i or negedge por_ni) begin
        if (!por_ni) wu_pend <= '0;
        else         wu_pend <= clr_wu_i;
      end
    end
  endgenerate

  assign wu_clr_now = wu_pend[CLR_DLY-1];

  // set beats clear
  always_ff @(posedge clk_i or negedge por_ni) begin
    if (!por_ni) begin
      sb_o <= 1'b0;
      wu_o <= 1'b0;
    end else begin
      if (set_sb_i)      sb_o <= 1'b1;
      else if (clr_sb_i) sb_o <= 1'b0;
      if (set_wu_i)        wu_o <= 1'b1;
      else if (wu_clr_now) wu_o <= 1'b0;
    end
  end

  p_sb_clr_r3: assert property (@(posedge clk_i) disable iff (!por_ni)
    (clr_sb_i && !set_sb_i) |=> !sb_o);

  p_wu_not_early_r4: assert property (@(posedge clk_i) disable iff (!por_ni)
    (clr_wu_i && wu_o && !wu_clr_now && !set_wu_i) |=> wu_o);

  p_set_wins_sb_r5: assert property (@(posedge clk_i) disable iff (!por_ni)
    set_sb_i |=> sb_o);

  p_set_wins_wu_r5: assert property (@(posedge clk_i) disable iff (!por_ni)
    set_wu_i |=> wu_o);
endmodule

// File: rtl/pwr_mode_sel.sv
module pwr_mode_sel (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic deepsleep_i,
  input  logic pwrdn_sel_i,
  input  logic lp_deep_i,
  output logic stby_req_o,
  output logic stop_req_o,
  output logic reg_lp_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stby_req_o <= 1'b0;
      stop_req_o <= 1'b0;
      reg_lp_o   <= 1'b0;
    end else begin
      stby_req_o <= deepsleep_i && pwrdn_sel_i;
      stop_req_o <= deepsleep_i && !pwrdn_sel_i;
      reg_lp_o   <= deepsleep_i && !pwrdn_sel_i && lp_deep_i;
    end
  end

  p_stby_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (deepsleep_i && pwrdn_sel_i) |=> (stby_req_o && !stop_req_o && !reg_lp_o));

  p_stop_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (deepsleep_i && !pwrdn_sel_i) |=> (stop_req_o && !stby_req_o && (reg_lp_o == $past(lp_deep_i))));

  p_awake_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !deepsleep_i |=> !(stby_req_o || stop_req_o || reg_lp_o));
endmodule

// File: rtl/pwr_mode_regs.sv
module pwr_mode_regs
  import pwr_regs_pkg::*;
#(
  parameter int ADDR_W    = 8,
  parameter int STAT_WAIT = 1,
  parameter int CLR_DLY   = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              por_ni,
  input  logic              psel_i,
  input  logic              penable_i,
  input  logic              pwrite_i,
  input  logic [ADDR_W-1:0] paddr_i,
  input  logic [31:0]       pwdata_i,
  output logic [31:0]       prdata_o,
  output logic              pready_o,
  output logic              pslverr_o,
  input  logic              deepsleep_i,
  input  logic              wkup_evt_i,
  input  logic              stby_exit_evt_i,
  input  logic              det_out_i,
  input  logic              bkreg_rdy_i,
  input  logic              vscale_rdy_i,
  output logic              stby_req_o,
  output logic              stop_req_o,
  output logic              reg_lp_o,
  output logic              det_en_o,
  output logic              wkpin_en_o,
  output logic              bkreg_en_o
);
  reg_sel_e sel;
  logic     wr_stb;
  logic     wr_ctrl;
  logic     wr_stat;
  ctrl_t    ctrl_q;
  stat_rw_t stat_q;
  logic     sb_flag;
  logic     wu_flag;
  logic     clr_sb;
  logic     clr_wu;
  logic [DATA_W-1:0] ctrl_rd;
  logic [DATA_W-1:0] stat_rd;

  pwr_apb_if #(
    .ADDR_W   (ADDR_W),
    .STAT_WAIT(STAT_WAIT)
  ) u_apb (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .psel_i   (psel_i),
    .penable_i(penable_i),
    .pwrite_i (pwrite_i),
    .paddr_i  (paddr_i),
    .pready_o (pready_o),
    .wr_stb_o (wr_stb),
    .sel_o    (sel)
  );

  assign wr_ctrl   = wr_stb && (sel == SEL_CTRL);
  assign wr_stat   = wr_stb && (sel == SEL_STAT);
  assign clr_sb    = wr_ctrl && pwdata_i[CT_CLR_SB];
  assign clr_wu    = wr_ctrl && pwdata_i[CT_CLR_WU];
  assign pslverr_o = 1'b0;

  // control: system reset domain
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q <= '0;
    end else if (wr_ctrl) begin
      ctrl_q.det_en    <= pwdata_i[CT_DET_EN];
      ctrl_q.pwrdn_sel <= pwdata_i[CT_PWRDN];
      ctrl_q.lp_deep   <= pwdata_i[CT_LP_DEEP];
    end
  end

  // status enables: power-on reset domain, kept across standby exit
  always_ff @(posedge clk_i or negedge por_ni) begin
    if (!por_ni) begin
      stat_q <= '0;
    end else if (wr_stat) begin
      stat_q.wkpin_en <= pwdata_i[ST_WKP_EN];
      stat_q.bkreg_en <= pwdata_i[ST_BKR_EN];
    end
  end

  pwr_flags #(
    .CLR_DLY(CLR_DLY)
  ) u_flags (
    .clk_i   (clk_i),
    .por_ni  (por_ni),
    .set_sb_i(stby_exit_evt_i),
    .set_wu_i(wkup_evt_i),
    .clr_sb_i(clr_sb),
    .clr_wu_i(clr_wu),
    .sb_o    (sb_flag),
    .wu_o    (wu_flag)
  );

  pwr_mode_sel u_mode (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .deepsleep_i(deepsleep_i),
    .pwrdn_sel_i(ctrl_q.pwrdn_sel),
    .lp_deep_i  (ctrl_q.lp_deep),
    .stby_req_o (stby_req_o),
    .stop_req_o (stop_req_o),
    .reg_lp_o   (reg_lp_o)
  );

  always_comb begin
    ctrl_rd             = '0;
    ctrl_rd[CT_DET_EN]  = ctrl_q.det_en;
    ctrl_rd[CT_PWRDN]   = ctrl_q.pwrdn_sel;
    ctrl_rd[CT_LP_DEEP] = ctrl_q.lp_deep;
  end

  always_comb begin
    stat_rd             = '0;
    stat_rd[ST_WU]      = wu_flag;
    stat_rd[ST_SB]      = sb_flag;
    stat_rd[ST_DET]     = det_out_i;
    stat_rd[ST_BKR_RDY] = bkreg_rdy_i;
    stat_rd[ST_WKP_EN]  = stat_q.wkpin_en;
    stat_rd[ST_BKR_EN]  = stat_q.bkreg_en;
    stat_rd[ST_VS_RDY]  = vscale_rdy_i;
  end

  always_comb begin
    unique case (sel)
      SEL_CTRL: prdata_o = ctrl_rd;
      SEL_STAT: prdata_o = stat_rd;
      default:  prdata_o = '0;
    endcase
  end

  assign det_en_o   = ctrl_q.det_en;
  assign wkpin_en_o = stat_q.wkpin_en;
  assign bkreg_en_o = stat_q.bkreg_en;

  p_unmapped_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (psel_i && (sel == SEL_NONE)) |-> (prdata_o == '0 && !pslverr_o));

  p_stat_hold_r9: assert property (@(posedge clk_i) disable iff (!por_ni)
    !wr_stat |=> $stable(stat_q));
endmodule

// File: tb/pwr_mode_regs_tb_top.sv
module pwr_mode_regs_tb_top;
  localparam int CTRL_A = 8'h00;
  localparam int STAT_A = 8'h04;

  logic        clk = 1'b0;
  logic        rst_n, por_n;
  logic        psel, penable, pwrite;
  logic [7:0]  paddr;
  logic [31:0] pwdata, prdata;
  logic        pready, pslverr;
  logic        deepsleep, wkup_evt, stby_evt, det_out, bkr_rdy, vs_rdy;
  logic        stby_req, stop_req, reg_lp, det_en, wkpin_en, bkreg_en;

  int n_chk = 0;
  int n_err = 0;

  // model state
  logic m_det, m_pd, m_lp, m_wu, m_sb, m_wkp, m_bke;

  always #2 clk = ~clk;

  pwr_mode_regs dut_i (
    .clk_i(clk), .rst_ni(rst_n), .por_ni(por_n),
    .psel_i(psel), .penable_i(penable), .pwrite_i(pwrite), .paddr_i(paddr),
    .pwdata_i(pwdata), .prdata_o(prdata), .pready_o(pready), .pslverr_o(pslverr),
    .deepsleep_i(deepsleep), .wkup_evt_i(wkup_evt), .stby_exit_evt_i(stby_evt),
    .det_out_i(det_out), .bkreg_rdy_i(bkr_rdy), .vscale_rdy_i(vs_rdy),
    .stby_req_o(stby_req), .stop_req_o(stop_req), .reg_lp_o(reg_lp),
    .det_en_o(det_en), .wkpin_en_o(wkpin_en), .bkreg_en_o(bkreg_en)
  );

  function automatic logic [31:0] exp_ctrl();
    logic [31:0] v = '0;
    v[4] = m_det; v[1] = m_pd; v[0] = m_lp;
    return v;
  endfunction

  function automatic logic [31:0] exp_stat();
    logic [31:0] v = '0;
    v[0] = m_wu; v[1] = m_sb; v[2] = det_out; v[3] = bkr_rdy;
    v[8] = m_wkp; v[9] = m_bke; v[14] = vs_rdy;
    return v;
  endfunction

  task automatic report();
    $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic xfer(input logic wr, input logic [7:0] a, input logic [31:0] d,
                      output logic [31:0] rd, output int w);
    @(negedge clk);
    psel = 1'b1; pwrite = wr; paddr = a; pwdata = d; penable = 1'b0;
    @(negedge clk);
    penable = 1'b1; w = 0;
    #1;
    while (!pready) begin
      @(negedge clk); #1; w++;
    end
    rd = prdata;
    chk("R10 pslverr", {31'b0, pslverr}, 32'h0);
    @(negedge clk);
    psel = 1'b0; penable = 1'b0;
  endtask

  task automatic wr_reg(input logic [7:0] a, input logic [31:0] d);
    logic [31:0] rd; int w;
    xfer(1'b1, a, d, rd, w);
    chk("R8 write waits", w, 0);
  endtask

  task automatic rd_reg(input logic [7:0] a, output logic [31:0] rd);
    int w;
    xfer(1'b0, a, 32'h0, rd, w);
    chk("R8 read waits", w, (a == STAT_A) ? 1 : 0);
  endtask

  task automatic ctrl_write(input logic [31:0] d);
    wr_reg(CTRL_A, d);
    m_det = d[4]; m_pd = d[1]; m_lp = d[0];
    if (d[3]) m_sb = 1'b0;
    if (d[2]) m_wu = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  task automatic pulse(input logic wu, input logic sb);
    wkup_evt = wu; stby_evt = sb;
    @(negedge clk);
    wkup_evt = 1'b0; stby_evt = 1'b0;
    if (wu) m_wu = 1'b1;
    if (sb) m_sb = 1'b1;
  endtask

  task automatic chk_mode(input logic ds);
    deepsleep = ds;
    @(negedge clk);
    chk("R1 stby_req", {31'b0, stby_req}, {31'b0, ds && m_pd});
    chk("R2 stop_req", {31'b0, stop_req}, {31'b0, ds && !m_pd});
    chk("R2 reg_lp", {31'b0, reg_lp}, {31'b0, ds && !m_pd && m_lp});
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL watchdog act=running exp=done");
    report();
  end

  initial begin
    logic [31:0] rd;
    void'($urandom(32'h5eed_0042));
    rst_n = 0; por_n = 0;
    psel = 0; penable = 0; pwrite = 0; paddr = 0; pwdata = 0;
    deepsleep = 0; wkup_evt = 0; stby_evt = 0; det_out = 0; bkr_rdy = 0; vs_rdy = 0;
    {m_det, m_pd, m_lp, m_wu, m_sb, m_wkp, m_bke} = '0;
    repeat (3) @(negedge clk);
    rst_n = 1; por_n = 1;

    // reset state
    rd_reg(CTRL_A, rd); chk("R6 ctrl reset", rd, 32'h0);
    rd_reg(STAT_A, rd); chk("R7 stat reset", rd, 32'h0);
    chk("R2 outputs reset", {26'b0, stby_req, stop_req, reg_lp, det_en, wkpin_en, bkreg_en}, 32'h0);

    // control layout, command bits read 0
    ctrl_write(32'hFFFF_FFFF);
    rd_reg(CTRL_A, rd); chk("R6 R3 R4 ctrl readback", rd, 32'h13);
    chk("R6 det_en_o", {31'b0, det_en}, 32'h1);

    // status layout: read-only bits ignore writes
    det_out = 1; bkr_rdy = 1; vs_rdy = 1;
    wr_reg(STAT_A, 32'hFFFF_FFFF); m_wkp = 1; m_bke = 1;
    rd_reg(STAT_A, rd); chk("R7 stat layout", rd, 32'h0000_430C);
    chk("R7 enables out", {30'b0, bkreg_en, wkpin_en}, 32'h3);

    // standby flag set, clear-0 no effect, clear-1 clears
    pulse(1'b0, 1'b1);
    ctrl_write(32'h0);
    rd_reg(STAT_A, rd); chk("R3 write 0 keeps sb", rd, exp_stat());
    ctrl_write(32'h8);
    rd_reg(STAT_A, rd); chk("R3 clear sb", rd, exp_stat());

    // wakeup clear delay: event one edge after the write is cleared
    pulse(1'b1, 1'b0);
    wr_reg(CTRL_A, 32'h4);
    pulse(1'b1, 1'b0);
    repeat (3) @(negedge clk);
    m_wu = 1'b0;
    rd_reg(STAT_A, rd); chk("R4 clear lands at edge +2", rd, exp_stat());
    // event two edges after the write coincides with the clear: set wins
    wr_reg(CTRL_A, 32'h4);
    @(negedge clk);
    pulse(1'b1, 1'b0);
    repeat (3) @(negedge clk);
    rd_reg(STAT_A, rd); chk("R5 R4 set wins at edge +2", rd, exp_stat());
    m_det = 0; m_pd = 0; m_lp = 0;

    // standby clear and event on the same edge
    @(negedge clk);
    psel = 1; pwrite = 1; paddr = CTRL_A; pwdata = 32'h8; penable = 0;
    @(negedge clk);
    penable = 1; stby_evt = 1;
    @(negedge clk);
    psel = 0; penable = 0; stby_evt = 0; m_sb = 1;
    rd_reg(STAT_A, rd); chk("R5 sb set wins", rd, exp_stat());

    // unmapped offsets
    wr_reg(8'h08, 32'hFFFF_FFFF);
    rd_reg(8'h08, rd); chk("R10 unmapped read", rd, 32'h0);
    rd_reg(8'hFC, rd); chk("R10 high unmapped read", rd, 32'h0);
    rd_reg(CTRL_A, rd); chk("R10 ctrl untouched", rd, exp_ctrl());
    rd_reg(STAT_A, rd); chk("R10 stat untouched", rd, exp_stat());

    // system reset keeps status
    ctrl_write(32'h13);
    @(negedge clk); rst_n = 0;
    @(negedge clk); rst_n = 1;
    m_det = 0; m_pd = 0; m_lp = 0;
    rd_reg(CTRL_A, rd); chk("R9 ctrl reset by rst_ni", rd, 32'h0);
    rd_reg(STAT_A, rd); chk("R9 stat kept", rd, exp_stat());

    // directed modes
    ctrl_write(32'h2); chk_mode(1'b1); chk_mode(1'b0);
    ctrl_write(32'h1); chk_mode(1'b1);
    ctrl_write(32'h0); chk_mode(1'b1); chk_mode(1'b0);

    // random mix
    for (int i = 0; i < 200; i++) begin
      int op = $urandom_range(0, 5);
      det_out = 1'($urandom); bkr_rdy = 1'($urandom); vs_rdy = 1'($urandom);
      case (op)
        0: begin ctrl_write($urandom); chk_mode(1'($urandom)); end
        1: begin
             logic [31:0] d = $urandom;
             wr_reg(STAT_A, d); m_wkp = d[8]; m_bke = d[9];
           end
        2: begin rd_reg(CTRL_A, rd); chk("R6 rand ctrl", rd, exp_ctrl()); end
        3: begin rd_reg(STAT_A, rd); chk("R7 rand stat", rd, exp_stat()); end
        4: begin
             logic [7:0] a = 8'($urandom_range(2, 63) << 2);
             rd_reg(a, rd); chk("R10 rand unmapped", rd, 32'h0);
           end
        default: begin pulse(1'($urandom), 1'($urandom)); chk_mode(1'($urandom)); end
      endcase
    end

    // power-on reset clears status
    @(negedge clk); por_n = 0; rst_n = 0;
    @(negedge clk); por_n = 1; rst_n = 1;
    det_out = 0; bkr_rdy = 0; vs_rdy = 0;
    rd_reg(STAT_A, rd); chk("R9 por clears stat", rd, 32'h0);

    report();
  end
endmodule